// File: doc/BRIEF.md
# Single-Master I2C Transaction Sequencer

This block runs one complete I2C transaction as the only master on the bus. A transaction is described by a byte buffer and a length. Buffer entry 0 holds the 7-bit target address in its upper bits and the transfer direction in bit 0. The remaining entries are either sent to the target or overwritten with bytes read from it. After a one-cycle `start` pulse the block checks the request and produces a start condition. It then clocks the address and the data bytes, and ends with a stop condition. It reports a 3-bit status code and pulses `done`.

The buffer is external. The block presents `buf_addr` and expects `buf_rdata` to reflect that address in the same cycle. It writes read data back through `buf_we`/`buf_wdata`. SCL and SDA are open-drain: an `*_oe` output of 1 pulls the line low, and `*_in` returns the resolved line level. The low and high phases of SCL come from cycle-count parameters, with one pair for standard speed and one for fast speed. The `fast` input picks the pair.

Status codes: 0 success, 1 no data, 2 stray start pending, 3 stray stop pending, 4 collision pending, 5 address not acknowledged, 6 data byte not acknowledged.

Top module: `i2c_txn_seq`

## Requirements
- R1: Bit 0 of buffer entry 0 sets the direction (1 = read, 0 = write). On a read the master never pulls SDA during data bits, and buffer entries 1..len-1 receive the bytes clocked in, MSB first.
- R2: The address byte is sent exactly once per transaction, first. If the target leaves its acknowledge bit high, the status becomes 5 and a stop follows at once, with no data byte clocked.
- R3: On a write, an unacknowledged data byte at buffer index k sets status 6, and the stop follows right after that byte. Exactly k+1 bytes appear on the bus.
- R4: On a read, the master pulls SDA low in the acknowledge bit of every byte except the last. It leaves SDA high in the last one.
- R5: A transaction begins with SCL released and seen high. The start condition is SDA falling while SCL is high, and exactly one start occurs per accepted transaction.
- R6: Every transaction that reached the bus ends with one stop condition, SDA rising while SCL is high.
- R7: Each SCL high phase is timed from the moment SCL is observed high. A target holding SCL low stretches the clock, and every high phase still lasts at least the high-phase count of the selected speed.
- R8: A length of 0 or 1 gives status 1 and causes no activity on SCL or SDA.
- R9: A pending stray start, stray stop or collision gives status 2, 3 or 4, with no bus activity. The priority is no-data, then start, then stop, then collision.
- R10: Status reads 0 from the cycle after an accepted `start`. When the transaction ends it shows the result (0 on success) and holds that value until the next accepted `start`.
- R11: `busy` rises the cycle after an accepted `start` and falls together with a one-cycle `done` pulse after the stop completes. A `start` while busy has no effect.
- R12: While not busy, both `scl_oe` and `sda_oe` are 0.
- R13: Write bytes leave MSB first, in buffer order, starting with entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to run a transaction |
| fast | input | 1 | Selects fast-speed phase counts |
| len | input | AW+1 | Number of buffer bytes including the address byte |
| pend_start | input | 1 | A stray start event is pending |
| pend_stop | input | 1 | A stray stop event is pending |
| pend_col | input | 1 | A data collision is pending |
| buf_addr | output | AW | Buffer index being accessed |
| buf_rdata | input | DW | Buffer content at `buf_addr` (zero latency) |
| buf_we | output | 1 | Write strobe for a byte read from the bus |
| buf_wdata | output | DW | Byte read from the bus |
| scl_in | input | 1 | Resolved SCL level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_in | input | 1 | Resolved SDA level |
| sda_oe | output | 1 | 1 pulls SDA low |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| status | output | 3 | Result code of the last transaction |

## Verification
The bench puts a behavioural target on the wired-AND lines. It can stretch every low phase well beyond the master's own low time. A master that starts its high-phase count at release rather than at the observed rising edge then shows short high phases. The target refuses the address, or a chosen data byte, at random. A sequencer that keeps clocking would show too many bytes, and one that mixes up the two refusal cases would report the wrong code. Reads check the acknowledge pattern and the bytes written back. Getting the last-byte rule wrong makes the final acknowledge low or an earlier one high. Rejections with every mix of pending flags and short lengths expose a wrong priority, and a wrongly rejected request still touches the bus.

// File: rtl/i2c_txn_pkg.sv
package i2c_txn_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_CHECK, S_REL, S_PRE, S_STA, S_STB, S_LOAD,
    S_LOW, S_RISE, S_HIGH, S_SPL, S_SPR, S_SPH, S_SPE
  } seq_st_t;

  typedef logic [2:0] txn_code_t;
  localparam txn_code_t C_OK       = 3'd0;
  localparam txn_code_t C_NODATA   = 3'd1;
  localparam txn_code_t C_UE_START = 3'd2;
  localparam txn_code_t C_UE_STOP  = 3'd3;
  localparam txn_code_t C_UE_COL   = 3'd4;
  localparam txn_code_t C_NACK_ADR = 3'd5;
  localparam txn_code_t C_NACK_DAT = 3'd6;
endpackage

// File: rtl/i2c_qdelay.sv
module i2c_qdelay #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] val,
  output logic          zero
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (load)      cnt <= val;
    else if (cnt != '0) cnt <= cnt - CW'(1);
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/i2c_shreg.sv
module i2c_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         shift,
  input  logic         bin,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= '1;
    else if (load)  q <= din;
    else if (shift) q <= {q[W-2:0], bin};
  end
endmodule

// File: rtl/i2c_txn_seq.sv
module i2c_txn_seq
  import i2c_txn_pkg::*;
#(
  parameter int AW        = 4,
  parameter int DW        = 8,
  parameter int LOW_STD   = 8,
  parameter int HIGH_STD  = 6,
  parameter int LOW_FAST  = 4,
  parameter int HIGH_FAST = 3,
  localparam int LW       = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          fast,
  input  logic [LW-1:0] len,
  input  logic          pend_start,
  input  logic          pend_stop,
  input  logic          pend_col,
  output logic [AW-1:0] buf_addr,
  input  logic [DW-1:0] buf_rdata,
  output logic          buf_we,
  output logic [DW-1:0] buf_wdata,
  input  logic          scl_in,
  output logic          scl_oe,
  input  logic          sda_in,
  output logic          sda_oe,
  output logic          busy,
  output logic          done,
  output logic [2:0]    status
);
  localparam int MS = (LOW_STD > HIGH_STD) ? LOW_STD : HIGH_STD;
  localparam int MF = (LOW_FAST > HIGH_FAST) ? LOW_FAST : HIGH_FAST;
  localparam int MX = (MS > MF) ? MS : MF;
  localparam int CW = $clog2(MX + 1);
  localparam int BW = $clog2(DW + 1);

  seq_st_t       st, nxt;
  logic [BW-1:0] bitc;
  logic [AW-1:0] idx;
  logic [LW-1:0] len_q;
  logic          rd_q, adr_q, fast_q, last;
  txn_code_t     err_q, rej;
  logic          tmr_load, tmr_zero, dly_done;
  logic [CW-1:0] tmr_val;
  logic [DW-1:0] sh_q;
  logic          sh_shift, to_slave;

  i2c_qdelay #(.CW(CW)) u_dly (
    .clk(clk), .rst(rst), .load(tmr_load), .val(tmr_val), .zero(tmr_zero)
  );

  i2c_shreg #(.W(DW)) u_sh (
    .clk(clk), .rst(rst), .load(st == S_LOAD),
    .din((adr_q || !rd_q) ? buf_rdata : '1),
    .shift(sh_shift), .bin(sda_in), .q(sh_q)
  );

  assign dly_done = !tmr_load && tmr_zero;
  assign last     = ({1'b0, idx} == len_q - LW'(1));
  assign to_slave = adr_q || !rd_q;
  assign sh_shift = (st == S_HIGH) && dly_done && (bitc != BW'(DW));
  assign buf_addr = idx;

  // Rejection priority: empty buffer, then stray start, stray stop, collision.
  always_comb begin
    if (len_q <= LW'(1))  rej = C_NODATA;
    else if (pend_start)  rej = C_UE_START;
    else if (pend_stop)   rej = C_UE_STOP;
    else if (pend_col)    rej = C_UE_COL;
    else                  rej = C_OK;
  end

  function automatic logic [CW-1:0] dly_of(input seq_st_t s, input logic f);
    case (s)
      S_PRE:               dly_of = f ? CW'(HIGH_FAST) : CW'(LOW_STD);
      S_STA, S_HIGH, S_SPH: dly_of = f ? CW'(HIGH_FAST) : CW'(HIGH_STD);
      S_LOW, S_SPL, S_SPE:  dly_of = f ? CW'(LOW_FAST)  : CW'(LOW_STD);
      default:             dly_of = '0;
    endcase
  endfunction

  always_comb begin
    nxt = st;
    case (st)
      S_IDLE:  if (start) nxt = S_CHECK;
      S_CHECK: nxt = (rej != C_OK) ? S_IDLE : S_REL;
      S_REL:   if (scl_in) nxt = S_PRE;
      S_PRE:   if (dly_done) nxt = S_STA;
      S_STA:   if (dly_done) nxt = S_STB;
      S_STB:   nxt = S_LOAD;
      S_LOAD:  nxt = S_LOW;
      S_LOW:   if (dly_done) nxt = S_RISE;
      S_RISE:  if (scl_in) nxt = S_HIGH;
      S_HIGH: begin
        if (dly_done) begin
          if (bitc != BW'(DW))              nxt = S_LOW;
          else if ((to_slave && sda_in) || last) nxt = S_SPL;
          else                               nxt = S_LOAD;
        end
      end
      S_SPL:   if (dly_done) nxt = S_SPR;
      S_SPR:   if (scl_in) nxt = S_SPH;
      S_SPH:   if (dly_done) nxt = S_SPE;
      S_SPE:   if (dly_done) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE;  bitc <= '0;   idx <= '0;   len_q <= '0;
      rd_q <= 1'b0;  adr_q <= 1'b1; fast_q <= 1'b0; err_q <= C_OK;
      tmr_load <= 1'b0; tmr_val <= '0;
      busy <= 1'b0;  done <= 1'b0; status <= C_OK;
      scl_oe <= 1'b0; sda_oe <= 1'b0; buf_we <= 1'b0; buf_wdata <= '0;
    end else begin
      st       <= nxt;
      tmr_load <= (nxt != st);
      tmr_val  <= dly_of(nxt, fast_q);
      busy     <= (nxt != S_IDLE);
      done     <= (st != S_IDLE) && (nxt == S_IDLE);
      scl_oe   <= (nxt == S_STB) || (nxt == S_LOAD) || (nxt == S_LOW) || (nxt == S_SPL);
      buf_we   <= 1'b0;
      case (st)
        S_IDLE: begin
          sda_oe <= 1'b0;
          if (start) begin
            len_q <= len;  fast_q <= fast;  status <= C_OK;
            idx <= '0;     adr_q <= 1'b1;   rd_q <= 1'b0;
            err_q <= C_OK; bitc <= '0;
          end
        end
        S_CHECK: if (rej != C_OK) status <= rej;
        S_STA, S_STB, S_SPL: sda_oe <= 1'b1;
        S_LOAD: begin
          sda_oe <= 1'b0;
          bitc   <= '0;
          if (adr_q) rd_q <= buf_rdata[0];
        end
        S_LOW: begin
          if (bitc == BW'(DW)) sda_oe <= rd_q && !adr_q && !last;
          else                 sda_oe <= to_slave && !sh_q[DW-1];
          if (tmr_load && (bitc == BW'(DW)) && rd_q && !adr_q) begin
            buf_we    <= 1'b1;
            buf_wdata <= sh_q;
          end
        end
        S_HIGH: begin
          if (dly_done) begin
            if (bitc != BW'(DW)) bitc <= bitc + BW'(1);
            else begin
              adr_q <= 1'b0;
              idx   <= idx + AW'(1);
              if (to_slave && sda_in) err_q <= adr_q ? C_NACK_ADR : C_NACK_DAT;
            end
          end
        end
        S_SPE: begin
          sda_oe <= 1'b0;
          if (dly_done) status <= err_q;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_txn_seq_chk.sv
module i2c_txn_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic [2:0] status,
  input logic       scl_oe,
  input logic       scl_in,
  input logic       sda_oe,
  input logic       buf_we
);
  // R12
  lines_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!scl_oe && !sda_oe));

  // R11
  busy_done_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R10
  status_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(status));

  // R10
  status_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> (status == 3'd0));

  // R7
  stretch_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (!scl_oe && !scl_in) |=> !scl_oe);

  // R1
  bufwr_busy_chk: assert property (@(posedge clk) disable iff (rst)
    buf_we |-> busy);
endmodule

bind i2c_txn_seq i2c_txn_seq_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .status(status), .scl_oe(scl_oe), .scl_in(scl_in), .sda_oe(sda_oe),
  .buf_we(buf_we)
);

// File: tb/i2c_txn_seq_bench.sv
`timescale 1ns/1ps
module i2c_txn_seq_bench;
  localparam int AW = 4, DW = 8, LS = 8, HS = 6, LF = 4, HF = 3;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, fast = 1'b0;
  logic [AW:0] len = '0;
  logic pend_start = 1'b0, pend_stop = 1'b0, pend_col = 1'b0;
  logic [AW-1:0] buf_addr;
  logic [DW-1:0] buf_rdata, buf_wdata;
  logic buf_we, scl_oe, sda_oe, busy, done;
  logic [2:0] status;
  logic sl_scl_hold = 1'b0, sl_sda_drv = 1'b0;
  wire scl_line = !(scl_oe || sl_scl_hold);
  wire sda_line = !(sda_oe || sl_sda_drv);

  logic [7:0] mem [16];
  logic [7:0] exp_mem [16];
  assign buf_rdata = mem[buf_addr];

  int nchk = 0, nfail = 0;

  always #4 clk = ~clk;

  i2c_txn_seq #(.AW(AW), .DW(DW), .LOW_STD(LS), .HIGH_STD(HS),
                .LOW_FAST(LF), .HIGH_FAST(HF)) u_i2c_txn_seq (
    .clk(clk), .rst(rst), .start(start), .fast(fast), .len(len),
    .pend_start(pend_start), .pend_stop(pend_stop), .pend_col(pend_col),
    .buf_addr(buf_addr), .buf_rdata(buf_rdata), .buf_we(buf_we),
    .buf_wdata(buf_wdata), .scl_in(scl_line), .scl_oe(scl_oe),
    .sda_in(sda_line), .sda_oe(sda_oe), .busy(busy), .done(done),
    .status(status)
  );

  always @(posedge clk) if (buf_we) mem[buf_addr] <= buf_wdata;

  // ---------------- behavioural target ----------------
  int nack_at = -1, stretch = 0;
  logic [7:0] rd_data [16];
  logic [7:0] wr_bytes [16];
  logic mack [16];
  int bitc = 0, bytec = 0, starts = 0, stops = 0, falls = 0;
  int min_high = 9999, hi_cnt = 0, hcnt = 0;
  bit active = 0, rd_mode = 0, quiet = 0, first_fall = 0;
  logic prev_scl = 1'b1, prev_sda = 1'b1;
  logic [7:0] sh = '0;

  always @(posedge clk) begin
    logic c, d;
    c = scl_line; d = sda_line;
    if (hcnt > 0) begin hcnt--; if (hcnt == 0) sl_scl_hold <= 1'b0; end
    if (c) hi_cnt++;
    if (prev_scl && c && prev_sda && !d) begin
      active = 1; bitc = 0; bytec = 0; rd_mode = 0; quiet = 0;
      first_fall = 1; starts++; min_high = 9999; sl_sda_drv <= 1'b0;
    end else if (prev_scl && c && !prev_sda && d) begin
      active = 0; stops++; sl_sda_drv <= 1'b0;
    end else if (!prev_scl && c && active) begin
      if (bitc < 8 && (bytec == 0 || !rd_mode)) sh = {sh[6:0], d};
      else if (bitc == 8 && rd_mode && bytec > 0) begin
        mack[bytec] = d; if (d) quiet = 1;
      end
    end else if (prev_scl && !c) begin
      falls++;
      if (active) begin
        if (!first_fall && hi_cnt < min_high) min_high = hi_cnt;
        if (stretch > 0) begin hcnt = stretch; sl_scl_hold <= 1'b1; end
        if (first_fall) begin
          first_fall = 0; sl_sda_drv <= 1'b0;
        end else if (bitc == 7) begin
          bitc = 8;
          if (bytec == 0) rd_mode = sh[0];
          wr_bytes[bytec] = sh;
          if (bytec == 0 || !rd_mode) begin
            sl_sda_drv <= (nack_at != bytec);
            if (nack_at == bytec) quiet = 1;
          end else sl_sda_drv <= 1'b0;
        end else if (bitc == 8) begin
          bitc = 0; bytec++;
          if (rd_mode && !quiet && bytec < 16) sl_sda_drv <= !rd_data[bytec][7];
          else sl_sda_drv <= 1'b0;
        end else begin
          bitc++;
          if (rd_mode && bytec > 0 && !quiet) sl_sda_drv <= !rd_data[bytec][7-bitc];
          else sl_sda_drv <= 1'b0;
        end
      end
    end
    if (!c) hi_cnt = 0;
    prev_scl = c; prev_sda = d;
  end

  // ---------------- checking ----------------
  task automatic chk(input bit ok, input string req, input int act, input int ex);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, ex);
    end
  endtask

  function automatic int exp_code(int ln, bit rd, int nk, bit ps, bit pst, bit pc);
    if (ln <= 1) return 1;
    if (ps) return 2;
    if (pst) return 3;
    if (pc) return 4;
    if (nk == 0) return 5;
    if (!rd && nk > 0 && nk < ln) return 6;
    return 0;
  endfunction

  function automatic int exp_bytes(int ln, bit rd, int nk);
    if (nk == 0) return 1;
    if (!rd && nk > 0 && nk < ln) return nk + 1;
    return ln;
  endfunction

  task automatic run_txn(input int ln, input bit rd, input int nk, input int strl,
                         input bit fm, input bit ps, input bit pst, input bit pc,
                         input bit poke);
    int s0, p0, f0, code, nb, wd;
    mem[0] = {7'($urandom), rd};
    for (int i = 1; i < 16; i++) mem[i] = 8'($urandom);
    for (int i = 0; i < 16; i++) begin
      exp_mem[i] = mem[i]; rd_data[i] = 8'($urandom); mack[i] = 1'bx;
    end
    nack_at = nk; stretch = strl;
    s0 = starts; p0 = stops; f0 = falls;
    code = exp_code(ln, rd, nk, ps, pst, pc);
    nb = exp_bytes(ln, rd, nk);
    @(negedge clk);
    len = (AW+1)'(ln); fast = fm; pend_start = ps; pend_stop = pst; pend_col = pc;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R11 busy after start", int'(busy), 1);
    chk(status == 3'd0, "R10 status cleared", int'(status), 0);
    wd = 0;
    while (!done && wd < 20000) begin
      @(negedge clk); wd++;
      if (poke && wd == 40) begin
        len = 1; start = 1'b1;
        @(negedge clk);
        start = 1'b0; len = (AW+1)'(ln);
      end
    end
    chk(wd < 20000, "R11 done within watchdog", wd, 20000);
    pend_start = 1'b0; pend_stop = 1'b0; pend_col = 1'b0;
    chk(busy == 1'b0, "R11 busy low at done", int'(busy), 0);
    chk(int'(status) == code, (code == 5) ? "R2 status" : (code == 6) ? "R3 status" :
        (code == 1) ? "R8 status" : (code >= 2 && code <= 4) ? "R9 status" : "R10 status",
        int'(status), code);
    chk(!scl_oe && !sda_oe, "R12 lines released", int'({scl_oe, sda_oe}), 0);
    if (code >= 1 && code <= 4) begin
      chk(falls == f0 && starts == s0, code == 1 ? "R8 no bus activity" : "R9 no bus activity",
          falls - f0, 0);
    end else begin
      chk(starts - s0 == 1, "R5 one start", starts - s0, 1);
      chk(stops - p0 == 1, "R6 one stop", stops - p0, 1);
      chk(scl_line && sda_line, "R6 bus idle high", int'({scl_line, sda_line}), 3);
      chk(bytec == nb, rd ? "R2 bytes on bus" : "R3 bytes on bus", bytec, nb);
      chk(min_high >= (fm ? HF : HS), "R7 high phase length", min_high, fm ? HF : HS);
      chk(wr_bytes[0] == exp_mem[0], "R2 address byte", int'(wr_bytes[0]), int'(exp_mem[0]));
      if (!rd) begin
        for (int i = 1; i < nb; i++)
          chk(wr_bytes[i] == exp_mem[i], "R13 write byte", int'(wr_bytes[i]), int'(exp_mem[i]));
      end else if (code == 0) begin
        for (int i = 1; i < ln; i++) begin
          chk(mem[i] == rd_data[i], "R1 read byte stored", int'(mem[i]), int'(rd_data[i]));
          chk(mack[i] == (i == ln - 1), "R4 master ack bit", int'(mack[i]), int'(i == ln - 1));
        end
      end
    end
    repeat (6) @(negedge clk);
    chk(int'(status) == code, "R10 status held", int'(status), code);
  endtask

  initial begin
    void'($urandom(32'd5151));
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R11 reset idle", int'({busy, done}), 0);
    chk(status == 3'd0, "R10 reset status", int'(status), 0);
    chk(!scl_oe && !sda_oe, "R12 reset lines", int'({scl_oe, sda_oe}), 0);
    rst = 1'b0;
    @(negedge clk);
    // directed corners
    run_txn(0, 0, -1, 0, 0, 0, 0, 0, 0);   // R8 empty
    run_txn(1, 1, -1, 0, 0, 1, 0, 0, 0);   // R8 beats pending start
    run_txn(4, 0, -1, 0, 0, 1, 1, 1, 0);   // R9 start first
    run_txn(4, 0, -1, 0, 0, 0, 1, 1, 0);   // R9 stop next
    run_txn(4, 1, -1, 0, 1, 0, 0, 1, 0);   // R9 collision
    run_txn(4, 0, -1, 0, 0, 0, 0, 0, 1);   // R11 start ignored while busy
    run_txn(2, 1, -1, 20, 0, 0, 0, 0, 0);  // R4 single read byte, stretched
    run_txn(5, 1, 0, 0, 1, 0, 0, 0, 0);    // R2 read address refused
    run_txn(5, 0, 0, 20, 1, 0, 0, 0, 0);   // R2 write address refused
    run_txn(6, 0, 3, 0, 0, 0, 0, 0, 0);    // R3 data refused mid-buffer
    run_txn(3, 0, 2, 20, 1, 0, 0, 0, 0);   // R3 refused on final byte
    // constrained random mix
    for (int k = 0; k < 14; k++) begin
      int ln, nk;
      bit rd;
      ln = 2 + int'($urandom % 7);
      rd = 1'($urandom);
      if (rd) nk = ($urandom % 4 == 0) ? 0 : -1;
      else    nk = ($urandom % 3 == 0) ? int'($urandom % ln) : -1;
      run_txn(ln, rd, nk, ($urandom % 2) ? 20 : 0, 1'($urandom), 0, 0, 0, 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #(200000 * 8);
    nchk++; nfail++;
    $display("FAIL R11 global watchdog expired: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule